// File: doc/BRIEF.md
# Guard-Round-Sticky Mantissa Rounder

This block is the rounding stage placed between an arithmetic datapath and a result packer. It receives a mantissa whose two lowest bits are the guard and round positions, a separate sticky bit, the sign of the value and a two-bit rounding-mode selector. It discards the guard and round positions, decides from the mode, the sign and the three low-order indicators whether one unit must be added at the new least significant position, and returns the rounded mantissa, a flag saying whether it added one, and a flag saying that precision was lost.

The stage does not renormalize. When the shifted mantissa is all ones and is incremented, the overflow is presented on a separate carry output and the mantissa field wraps to zero; the packer that follows adjusts the exponent. The decision logic is combinational and the results are captured in one register stage, so a result appears one clock after its input strobe and is held until the next strobe.

A two-state controller tracks the output register: state ST_IDLE (no fresh result) and state ST_OUT (a result captured on the previous edge). Transition T_LOAD goes from either state to ST_OUT when the input strobe is high; transition T_DRAIN goes from either state to ST_IDLE when the strobe is low. Reset places the controller in ST_IDLE.

Top module: `grs_rounder`

## Requirements
- R1: After reset, out_valid, out_mant, out_carry, out_up and out_inexact are all 0.
- R2: out_valid is 1 in the cycle after a cycle with in_valid high and 0 otherwise; the result outputs change only on an edge where in_valid is high and otherwise keep their last value.
- R3: With in_mant bit 1 (guard), in_mant bit 0 (round) and in_sticky all 0, the result is in_mant shifted right by two, out_up is 0 and out_inexact is 0, in every mode.
- R4: out_inexact is 1 whenever guard, round or sticky is 1, in every mode.
- R5: Mode 2'b00 (nearest) adds one only when guard is 1 and at least one of round, sticky or the shifted mantissa's bit 0 is 1, so an exact half rounds to even.
- R6: Mode 2'b01 (toward zero) never adds one.
- R7: Mode 2'b10 (toward minus infinity) adds one only for an inexact value with in_sign 1; mode 2'b11 (toward plus infinity) adds one only for an inexact value with in_sign 0.
- R8: The addition spans the whole shifted mantissa; {out_carry, out_mant} equals the shifted mantissa plus the increment, so an all-ones mantissa that is incremented gives out_carry 1 and out_mant 0, with no renormalization.
- R9: out_up is 1 exactly when one was added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe; inputs are captured on this edge |
| in_mant | input | MANT_W | Mantissa; bit 1 guard, bit 0 round |
| in_sticky | input | 1 | Sticky indicator of bits below round |
| in_sign | input | 1 | Sign of the value, 1 = negative |
| in_mode | input | 2 | Rounding mode: 00 nearest, 01 to zero, 10 to minus infinity, 11 to plus infinity |
| out_valid | output | 1 | Result captured on the previous edge |
| out_mant | output | MANT_W-2 | Rounded mantissa without guard and round |
| out_carry | output | 1 | Overflow of the increment beyond the top bit |
| out_up | output | 1 | One was added |
| out_inexact | output | 1 | Guard, round or sticky was set |

## Verification
A wrong rounding decision shows as a mantissa off by one unit and a disagreeing out_up flag on the very next clock after the strobe, so every captured result is compared with a behavioural model at the following sample. A wrong controller state shows as out_valid asserted without a preceding strobe, or missing after one, or as result outputs that drift during idle cycles; both are visible one clock later, and the bench interleaves idle cycles with garbage inputs to expose them. Exact ties on even and odd mantissas and the all-ones carry case are driven directly.

// File: rtl/grs_pkg.sv
package grs_pkg;

    localparam int NG = 2;

    typedef enum logic [1:0] {
        RM_NEAR  = 2'b00,
        RM_ZERO  = 2'b01,
        RM_MINF  = 2'b10,
        RM_PINF  = 2'b11
    } grs_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } grs_state_e;

endpackage

// File: rtl/grs_decide.sv
module grs_decide
    import grs_pkg::*;
(
    input  logic       guard_i,
    input  logic       rnd_i,
    input  logic       sticky_i,
    input  logic       sign_i,
    input  logic       lsb_i,
    input  logic [1:0] mode_i,
    output logic       inc_o,
    output logic       inexact_o
);

    logic lost;
    grs_mode_e mode;

    assign lost      = guard_i | rnd_i | sticky_i;
    assign inexact_o = lost;
    assign mode      = grs_mode_e'(mode_i);

    always_comb begin
        inc_o = 1'b0;
        unique case (mode)
            RM_ZERO: inc_o = 1'b0;
            RM_MINF: inc_o = lost & sign_i;
            RM_PINF: inc_o = lost & ~sign_i;
            default: inc_o = guard_i & (rnd_i | sticky_i | lsb_i);
        endcase
    end

endmodule

// File: rtl/grs_incr.sv
module grs_incr #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic         inc_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);

    logic [W:0] wide;

    assign wide    = {1'b0, a_i} + {{W{1'b0}}, inc_i};
    assign sum_o   = wide[W-1:0];
    assign carry_o = wide[W];

endmodule

// File: rtl/grs_rounder.sv
module grs_rounder
    import grs_pkg::*;
#(
    parameter int MANT_W = 34
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [MANT_W-1:0]    in_mant,
    input  logic                 in_sticky,
    input  logic                 in_sign,
    input  logic [1:0]           in_mode,
    output logic                 out_valid,
    output logic [MANT_W-NG-1:0] out_mant,
    output logic                 out_carry,
    output logic                 out_up,
    output logic                 out_inexact
);

    localparam int RES_W = MANT_W - NG;

    grs_state_e state_q, state_d;

    logic [RES_W-1:0] shifted;
    logic [RES_W-1:0] sum;
    logic             carry;
    logic             inc;
    logic             inexact;

    assign shifted = in_mant[MANT_W-1:NG];

    grs_decide u_decide (
        .guard_i   (in_mant[1]),
        .rnd_i     (in_mant[0]),
        .sticky_i  (in_sticky),
        .sign_i    (in_sign),
        .lsb_i     (shifted[0]),
        .mode_i    (in_mode),
        .inc_o     (inc),
        .inexact_o (inexact)
    );

    grs_incr #(.W(RES_W)) u_incr (
        .a_i     (shifted),
        .inc_i   (inc),
        .sum_o   (sum),
        .carry_o (carry)
    );

    // next-state: T_LOAD on strobe, T_DRAIN otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_OUT : ST_IDLE;
            ST_OUT:  state_d = in_valid ? ST_OUT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_mant    <= '0;
            out_carry   <= 1'b0;
            out_up      <= 1'b0;
            out_inexact <= 1'b0;
        end else if (in_valid) begin
            out_mant    <= sum;
            out_carry   <= carry;
            out_up      <= inc;
            out_inexact <= inexact;
        end
    end

    assign out_valid = (state_q == ST_OUT);

    // R2: strobe produces out_valid one cycle later
    a_r2_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r2_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_mant) && $stable(out_up) && $stable(out_inexact)));
    // R3: an exact value never rounds up
    a_r3_exact_no_up: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_inexact) |-> !out_up);
    // R6: toward zero never increments
    a_r6_zero_no_up: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b01) |=> !out_up);
    // R8: carry only from an increment that wrapped the mantissa
    a_r8_carry_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        out_carry |-> (out_up && out_mant == '0));

endmodule

// File: tb/sim_grs_rounder.sv
module sim_grs_rounder;

    localparam int CLK_P  = 10;
    localparam int MANT_W = 34;
    localparam int RES_W  = MANT_W - 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [MANT_W-1:0] in_mant;
    logic              in_sticky;
    logic              in_sign;
    logic [1:0]        in_mode;
    logic              out_valid;
    logic [RES_W-1:0]  out_mant;
    logic              out_carry;
    logic              out_up;
    logic              out_inexact;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // expectations held for the next sample
    bit               e_valid   = 1'b0;
    logic [RES_W-1:0] e_mant    = '0;
    bit               e_carry   = 1'b0;
    bit               e_up      = 1'b0;
    bit               e_inexact = 1'b0;
    string            e_tag     = "R1";

    always #(CLK_P/2) clk = ~clk;

    grs_rounder #(.MANT_W(MANT_W)) u0 (
        .clk, .rst_n, .in_valid, .in_mant, .in_sticky, .in_sign, .in_mode,
        .out_valid, .out_mant, .out_carry, .out_up, .out_inexact
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(out_valid == e_valid, "R2", "out_valid", 64'(out_valid), 64'(e_valid));
        chk(out_mant == e_mant, e_tag, "out_mant", 64'(out_mant), 64'(e_mant));
        chk(out_carry == e_carry, "R8", "out_carry", 64'(out_carry), 64'(e_carry));
        chk(out_up == e_up, "R9", "out_up", 64'(out_up), 64'(e_up));
        chk(out_inexact == e_inexact, "R4", "out_inexact", 64'(out_inexact), 64'(e_inexact));
    endtask

    // one cycle: check what the last edge produced, then drive new inputs
    task automatic step(input bit v, input logic [MANT_W-1:0] m,
                        input bit s, input bit sg, input logic [1:0] md);
        bit g, r, lost, inc;
        logic [RES_W:0] total;
        @(negedge clk);
        compare_all();
        in_valid  = v;
        in_mant   = m;
        in_sticky = s;
        in_sign   = sg;
        in_mode   = md;
        e_valid   = v;
        if (v) begin
            g    = m[1];
            r    = m[0];
            lost = g | r | s;
            case (md)
                2'b01:   inc = 1'b0;
                2'b10:   inc = lost && sg;
                2'b11:   inc = lost && !sg;
                default: inc = g && (r || s || m[2]);
            endcase
            total     = {1'b0, m[MANT_W-1:2]} + (RES_W+1)'(inc);
            e_mant    = total[RES_W-1:0];
            e_carry   = total[RES_W];
            e_up      = inc;
            e_inexact = lost;
            if (!lost)           e_tag = "R3";
            else if (md == 2'b01) e_tag = "R6";
            else if (md[1])       e_tag = "R7";
            else                  e_tag = "R5";
        end else begin
            e_tag = "R2";
        end
    endtask

    initial begin
        int cycles = 0;
        while (!done && cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_mant = '0;
        in_sticky = 1'b0; in_sign = 1'b0; in_mode = 2'b00;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0 && out_mant == '0 && !out_carry && !out_up && !out_inexact,
            "R1", "reset outputs", {out_valid, out_carry, out_up, out_inexact, 28'h0, out_mant}, 64'h0);
        rst_n = 1'b1;

        // R3: exact values in every mode
        for (int md = 0; md < 4; md++) step(1, {32'h1234_5677, 2'b00}, 0, md[0], 2'(md));
        // R5: ties to even, even and odd
        step(1, {32'h0000_0010, 2'b10}, 0, 0, 2'b00);
        step(1, {32'h0000_0011, 2'b10}, 0, 0, 2'b00);
        step(1, {32'h0000_0010, 2'b10}, 1, 0, 2'b00);
        step(1, {32'h0000_0010, 2'b11}, 0, 1, 2'b00);
        step(1, {32'h0000_0010, 2'b01}, 1, 0, 2'b00);
        // R6: toward zero with everything set
        step(1, {32'h0000_0FFF, 2'b11}, 1, 1, 2'b01);
        // R7: directed modes by sign
        step(1, {32'h0000_0100, 2'b01}, 0, 1, 2'b10);
        step(1, {32'h0000_0100, 2'b01}, 0, 0, 2'b10);
        step(1, {32'h0000_0100, 2'b00}, 1, 0, 2'b11);
        step(1, {32'h0000_0100, 2'b00}, 1, 1, 2'b11);
        // R8: all-ones carry, nearest and plus infinity
        step(1, {32'hFFFF_FFFF, 2'b11}, 0, 0, 2'b00);
        step(0, '1, 1, 1, 2'b11);
        step(1, {32'hFFFF_FFFF, 2'b00}, 1, 0, 2'b11);
        step(1, {32'hFFFF_FFFF, 2'b10}, 0, 0, 2'b01);
        // R2: idle cycles with garbage keep the result
        step(0, 34'h2_AAAA_5555, 1, 1, 2'b11);
        step(0, 34'h1_5555_AAAA, 0, 0, 2'b00);

        for (int i = 0; i < 600; i++) begin
            logic [MANT_W-1:0] m;
            m = {$urandom(), $urandom()} & {MANT_W{1'b1}};
            if (i % 50 == 0) m = {{RES_W{1'b1}}, 2'($urandom())};
            step(($urandom() % 4) != 0, m, 1'($urandom()), 1'($urandom()), 2'($urandom()));
        end
        step(0, '0, 0, 0, 2'b00);
        @(negedge clk);
        compare_all();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule